// File: doc/BRIEF.md
# Context-Banked Carry/Zero Flag Store

This block keeps three separate carry/zero flag pairs for a small processor core. There is one pair for normal code, one for maskable interrupt service and one for non-maskable interrupt service. The pair that the core sees is picked from the current execution context. The block switches it by itself when the core enters an interrupt or a non-maskable interrupt, and when the core returns.

The ALU supplies new carry and zero values with separate write strobes. A write always lands in the pair of the context that is current on that clock edge. The other two pairs keep their values through any number of context switches.

A small record of return targets handles nesting. It holds up to `NEST_DEPTH` entries and has a default depth of two. This covers a non-maskable interrupt taken inside an interrupt. The machine comes out of reset in the non-maskable context with the record empty, so the first return lands in normal execution.

Top module: `ctx_flag_bank`

## Requirements
- R1: On a synchronous reset (`rst` high at a clock edge), `ctx_o` becomes 2 (non-maskable context) and the return record empties. All three flag pairs are cleared, so `carry_o` and `zero_o` read 0 in every context until they are written.
- R2: Context codes are normal = 0, interrupt = 1 and non-maskable = 2. One edge with `irq_enter` high (and `nmi_enter` low) sets `ctx_o` to 1. From that edge, `carry_o` and `zero_o` show the interrupt pair.
- R3: One edge with `nmi_enter` high sets `ctx_o` to 2. From that edge, the outputs show the non-maskable pair.
- R4: `irq_return` outside the normal context pops the newest entry of the return record, and that entry becomes the context. A non-maskable interrupt nested in an interrupt returns to the interrupt, and a second return then goes to normal.
- R5: A context switch never changes any flag pair. When a context is re-entered, its pair shows the values last written in it.
- R6: A flag write changes only the pair of the context that is current before the edge. This holds even when a context event happens on the same edge.
- R7: `flag_c_we` loads carry from `flag_c_in` and `flag_z_we` loads zero from `flag_z_in`, each on its own. A write of one flag leaves the other flag unchanged.
- R8: `irq_return` while in the normal context has no effect: `ctx_o` stays 0 and the flags stay as they are.
- R9: A return with an empty record moves to the normal context. This includes the first return after reset.
- R10: When strobes coincide on one edge, `nmi_enter` wins over `irq_enter`, and either entry wins over `irq_return`. The return is then dropped.
- R11: An entry with a full record pushes the current context and drops the oldest entry. Later returns unwind the kept entries and then reach normal.
- R12: All outputs are registered. A write with no context event shows on `carry_o`/`zero_o` right after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_c_we | input | 1 | Carry write strobe |
| flag_z_we | input | 1 | Zero write strobe |
| flag_c_in | input | 1 | New carry value from ALU |
| flag_z_in | input | 1 | New zero value from ALU |
| irq_enter | input | 1 | Maskable interrupt entry strobe |
| nmi_enter | input | 1 | Non-maskable interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| carry_o | output | 1 | Carry of the active pair |
| zero_o | output | 1 | Zero of the active pair |
| ctx_o | output | 2 | Current context code |

## Verification
A corrupted entry in the return record shows up on `ctx_o` at the return that pops it. That can be many cycles after the fault, so the bench unwinds nested entries all the way to normal. A write that lands in the wrong bank is hidden until that bank becomes active again. To catch it, the bench writes distinct values in each context and re-enters every context before it compares the flags. A reference model compares the outputs on every cycle, so any divergence is reported on the first clock at which it becomes visible.

// File: rtl/flagbank_pkg.sv
package flagbank_pkg;
  localparam int NUM_CTX = 3;
  localparam int CTX_W   = $clog2(NUM_CTX);

  typedef enum logic [CTX_W-1:0] {
    CTX_NORM = 2'd0,
    CTX_IRQ  = 2'd1,
    CTX_NMI  = 2'd2
  } ctx_e;
endpackage

// File: rtl/ctx_tracker.sv
module ctx_tracker
  import flagbank_pkg::*;
#(
  parameter int NEST_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_enter,
  input  logic             nmi_enter,
  input  logic             irq_return,
  output logic [CTX_W-1:0] ctx_q,
  output logic [CTX_W-1:0] ctx_nxt
);
  logic [CTX_W-1:0] rec_ctx [NEST_DEPTH];
  logic [NEST_DEPTH-1:0] rec_vld;
  logic push, pop;

  assign push = irq_enter | nmi_enter;
  assign pop  = irq_return & ~push & (ctx_q != CTX_NORM);

  always_comb begin
    ctx_nxt = ctx_q;
    if (nmi_enter)      ctx_nxt = CTX_NMI;
    else if (irq_enter) ctx_nxt = CTX_IRQ;
    else if (pop)       ctx_nxt = rec_vld[0] ? rec_ctx[0] : CTX_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst) ctx_q <= CTX_NMI;
    else     ctx_q <= ctx_nxt;
  end

  // return record: entry 0 is the newest
  generate
    for (genvar i = 0; i < NEST_DEPTH; i++) begin : g_rec
      always_ff @(posedge clk) begin
        if (rst) begin
          rec_ctx[i] <= CTX_NORM;
          rec_vld[i] <= 1'b0;
        end else if (push) begin
          if (i == 0) begin
            rec_ctx[i] <= ctx_q;
            rec_vld[i] <= 1'b1;
          end else begin
            rec_ctx[i] <= rec_ctx[(i == 0) ? 0 : i-1];
            rec_vld[i] <= rec_vld[(i == 0) ? 0 : i-1];
          end
        end else if (pop) begin
          if (i == NEST_DEPTH-1) begin
            rec_vld[i] <= 1'b0;
          end else begin
            rec_ctx[i] <= rec_ctx[(i == NEST_DEPTH-1) ? i : i+1];
            rec_vld[i] <= rec_vld[(i == NEST_DEPTH-1) ? i : i+1];
          end
        end
      end
    end
  endgenerate

  p_irq_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_enter && !nmi_enter) |=> (ctx_q == CTX_IRQ));
  p_nmi_entry_r3: assert property (@(posedge clk) disable iff (rst)
    nmi_enter |=> (ctx_q == CTX_NMI));
  p_norm_return_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !push && ctx_q == CTX_NORM) |=> (ctx_q == CTX_NORM));
  p_empty_return_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !push && !rec_vld[0]) |=> (ctx_q == CTX_NORM));
  p_ctx_legal_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ctx_q != 2'd3));
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import flagbank_pkg::*;
#(
  parameter int CTX_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTX_W-1:0] active,
  input  logic             c_we,
  input  logic             z_we,
  input  logic             c_in,
  input  logic             z_in,
  output logic             c_q,
  output logic             z_q,
  output logic             c_nxt,
  output logic             z_nxt
);
  logic mine;
  assign mine  = (active == CTX_W'(CTX_ID));
  assign c_nxt = (mine && c_we) ? c_in : c_q;
  assign z_nxt = (mine && z_we) ? z_in : z_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      c_q <= c_nxt;
      z_q <= z_nxt;
    end
  end

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (active != CTX_W'(CTX_ID)) |=> ($stable(c_q) && $stable(z_q)));
endmodule

// File: rtl/ctx_flag_bank.sv
module ctx_flag_bank
  import flagbank_pkg::*;
#(
  parameter int NEST_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_c_we,
  input  logic             flag_z_we,
  input  logic             flag_c_in,
  input  logic             flag_z_in,
  input  logic             irq_enter,
  input  logic             nmi_enter,
  input  logic             irq_return,
  output logic             carry_o,
  output logic             zero_o,
  output logic [CTX_W-1:0] ctx_o
);
  logic [CTX_W-1:0] ctx_q, ctx_nxt;
  logic [NUM_CTX-1:0] bc_q, bz_q, bc_nxt, bz_nxt;
  logic sel_c, sel_z;

  ctx_tracker #(.NEST_DEPTH(NEST_DEPTH)) u_trk (
    .clk(clk), .rst(rst), .irq_enter(irq_enter), .nmi_enter(nmi_enter),
    .irq_return(irq_return), .ctx_q(ctx_q), .ctx_nxt(ctx_nxt)
  );

  generate
    for (genvar b = 0; b < NUM_CTX; b++) begin : g_bank
      flag_bank #(.CTX_ID(b)) u_bank (
        .clk(clk), .rst(rst), .active(ctx_q),
        .c_we(flag_c_we), .z_we(flag_z_we),
        .c_in(flag_c_in), .z_in(flag_z_in),
        .c_q(bc_q[b]), .z_q(bz_q[b]),
        .c_nxt(bc_nxt[b]), .z_nxt(bz_nxt[b])
      );
    end
  endgenerate

  always_comb begin
    sel_c = 1'b0;
    sel_z = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (ctx_nxt == CTX_W'(i)) begin
        sel_c = bc_nxt[i];
        sel_z = bz_nxt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
    end else begin
      carry_o <= sel_c;
      zero_o  <= sel_z;
    end
  end

  assign ctx_o = ctx_q;

  p_out_shows_active_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (carry_o == bc_q[ctx_q] && zero_o == bz_q[ctx_q]));
  p_carry_load_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_c_we && !irq_enter && !nmi_enter && !irq_return)
      |=> (carry_o == $past(flag_c_in)));
  p_zero_untouched_r7: assert property (@(posedge clk) disable iff (rst)
    (!flag_z_we && !irq_enter && !nmi_enter && !irq_return) |=> $stable(zero_o));
  p_nmi_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (nmi_enter && irq_enter) |=> (ctx_o == CTX_NMI));
endmodule

// File: tb/tb_ctx_flag_bank.sv
module tb_ctx_flag_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cwe = 0, zwe = 0, cin = 0, zin = 0, irq = 0, nmi = 0, ret = 0;
  logic carry_o, zero_o;
  logic [1:0] ctx_o;

  int checks = 0, errors = 0, cycles = 0;
  int m_ctx;
  int m_rec[$];
  bit m_c[3], m_z[3];
  bit done = 0;

  ctx_flag_bank dut (
    .clk(clk), .rst(rst), .flag_c_we(cwe), .flag_z_we(zwe),
    .flag_c_in(cin), .flag_z_in(zin), .irq_enter(irq), .nmi_enter(nmi),
    .irq_return(ret), .carry_o(carry_o), .zero_o(zero_o), .ctx_o(ctx_o)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
        summary();
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctx = 2; m_rec.delete();
    for (int i = 0; i < 3; i++) begin m_c[i] = 0; m_z[i] = 0; end
  endtask

  task automatic model_step(bit a_cwe, bit a_zwe, bit a_c, bit a_z,
                            bit a_irq, bit a_nmi, bit a_ret);
    int prev = m_ctx;
    if (a_cwe) m_c[prev] = a_c;
    if (a_zwe) m_z[prev] = a_z;
    if (a_nmi || a_irq) begin
      m_rec.push_front(prev);
      if (m_rec.size() > 2) void'(m_rec.pop_back());
      m_ctx = a_nmi ? 2 : 1;
    end else if (a_ret && prev != 0) begin
      m_ctx = (m_rec.size() > 0) ? m_rec.pop_front() : 0;
    end
  endtask

  task automatic cyc(string tag, bit a_cwe, bit a_zwe, bit a_c, bit a_z,
                     bit a_irq, bit a_nmi, bit a_ret);
    cwe = a_cwe; zwe = a_zwe; cin = a_c; zin = a_z;
    irq = a_irq; nmi = a_nmi; ret = a_ret;
    @(posedge clk);
    model_step(a_cwe, a_zwe, a_c, a_z, a_irq, a_nmi, a_ret);
    @(negedge clk);
    cwe = 0; zwe = 0; irq = 0; nmi = 0; ret = 0;
    chk({tag, " ctx"}, ctx_o, m_ctx);
    chk({tag, " carry"}, carry_o, m_c[m_ctx]);
    chk({tag, " zero"}, zero_o, m_z[m_ctx]);
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 reset ctx", ctx_o, 2);
    chk("R1 reset carry", carry_o, 0);
    chk("R1 reset zero", zero_o, 0);
    // R12 / R7: write in NMI context, separate strobes
    cyc("R12 carry write", 1, 0, 1, 0, 0, 0, 0);
    chk("R12 carry now 1", carry_o, 1);
    cyc("R7 zero write keeps carry", 0, 1, 0, 1, 0, 0, 0);
    chk("R7 carry kept", carry_o, 1);
    // R9: first return after reset goes to normal
    cyc("R9 first return", 0, 0, 0, 0, 0, 0, 1);
    chk("R9 ctx normal", ctx_o, 0);
    chk("R1 normal bank zero", carry_o, 0);
    // R8: return in normal ignored
    cyc("R8 return in normal", 0, 0, 0, 0, 0, 0, 1);
    chk("R8 ctx stays 0", ctx_o, 0);
    cyc("R6 normal write", 1, 1, 0, 1, 0, 0, 0);
    // R2: interrupt entry, with same-edge write into normal bank (R6)
    cyc("R6 write with irq entry", 1, 0, 1, 0, 1, 0, 0);
    chk("R2 ctx irq", ctx_o, 1);
    chk("R1 irq bank zero", carry_o, 0);
    cyc("R2 irq write", 1, 1, 1, 1, 0, 0, 0);
    // R3: NMI nested in interrupt
    cyc("R3 nmi entry", 0, 0, 0, 0, 0, 1, 0);
    chk("R3 ctx nmi", ctx_o, 2);
    chk("R5 nmi bank kept carry", carry_o, 1);
    chk("R5 nmi bank kept zero", zero_o, 1);
    cyc("R6 nmi write", 1, 1, 0, 0, 0, 0, 0);
    // R4: unwind
    cyc("R4 return to irq", 0, 0, 0, 0, 0, 0, 1);
    chk("R4 ctx irq", ctx_o, 1);
    chk("R5 irq carry", carry_o, 1);
    cyc("R4 return to normal", 0, 0, 0, 0, 0, 0, 1);
    chk("R4 ctx normal", ctx_o, 0);
    chk("R6 normal carry from same-edge write", carry_o, 1);
    chk("R5 normal zero", zero_o, 1);
    // R10: priority
    cyc("R10 irq+nmi+ret", 0, 0, 0, 0, 1, 1, 1);
    chk("R10 nmi wins", ctx_o, 2);
    cyc("R10 irq+ret", 0, 0, 0, 0, 1, 0, 1);
    chk("R10 irq over ret", ctx_o, 1);
    // R11: overflow; record now [NMI, NORM], push IRQ drops NORM
    cyc("R11 overflow push", 0, 0, 0, 0, 0, 1, 0);
    cyc("R11 pop1", 0, 0, 0, 0, 0, 0, 1);
    chk("R11 pop1 irq", ctx_o, 1);
    cyc("R11 pop2", 0, 0, 0, 0, 0, 0, 1);
    chk("R11 pop2 nmi", ctx_o, 2);
    cyc("R11 pop3", 0, 0, 0, 0, 0, 0, 1);
    chk("R11 empty to normal", ctx_o, 0);
    // random traffic, model compared every clock
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      cyc("R5 R6 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          r < 8, r >= 8 && r < 13, r >= 70 || r == 9);
    end
    // R1: reset mid-run clears everything
    do_reset();
    chk("R1 re-reset ctx", ctx_o, 2);
    cyc("R1 irq after reset", 0, 0, 0, 0, 1, 0, 0);
    chk("R1 irq bank cleared", carry_o, 0);
    chk("R1 irq zero cleared", zero_o, 0);
    done = 1;
    summary();
  end
endmodule